// File: doc/BRIEF.md
# Mailbox Interrupt Flag Logic

This block sits next to a two-port shared memory with 10-bit addresses. It lets the two ports signal each other. It does not touch the memory array. It watches each port's select, write strobe, output enable and address. From those it keeps one active-low interrupt flag for each side.

The two highest addresses act as mailboxes:

- 0x3FF belongs to the right side.
- 0x3FE belongs to the left side.

When one side writes into the other side's mailbox, the other side's flag is pulled low. The owner releases its flag by reading its own mailbox. Every control input is active low:

- A write is select low with write strobe low.
- A read is select low, write strobe high and output enable low.

The inputs are sampled on the clock. An access counts once, on the first cycle in which all of its qualifiers hold together. So whichever qualifier arrives last triggers it. Holding an access for several cycles has no further effect. Reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `mbox_irq_unit`

## Requirements
- R1: While reset is asserted and after it is released, both `lt_irq_n` and `rt_irq_n` read 1 (inactive). Asserting reset forces them to 1 immediately.
- R2: A left write (`lt_cs_n`=0, `lt_wr_n`=0) to address 0x3FF drives `rt_irq_n` to 0 after the next rising clock edge.
- R3: A right write (`rt_cs_n`=0, `rt_wr_n`=0) to address 0x3FE drives `lt_irq_n` to 0 after the next rising clock edge.
- R4: A right read (`rt_cs_n`=0, `rt_wr_n`=1, `rt_oe_n`=0) of address 0x3FF returns `rt_irq_n` to 1 after the next rising clock edge.
- R5: A left read (`lt_cs_n`=0, `lt_wr_n`=1, `lt_oe_n`=0) of address 0x3FE returns `lt_irq_n` to 1 after the next rising clock edge.
- R6: The access takes effect in the cycle its last missing qualifier arrives. That qualifier may be the address, the write strobe or the output enable.
- R7: An access held over consecutive cycles acts only in its first cycle. A held read does not clear a flag that is set while it is held, and a held write does not set again a flag that is cleared while it is held.
- R8: When a set and a clear of the same flag occur in the same cycle, the flag ends up at 0.
- R9: The following leave both flags unchanged:
  - accesses to any other address;
  - a port reading the other port's mailbox;
  - a port writing its own mailbox;
  - a read with `*_oe_n`=1;
  - a write with `*_cs_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock sampling all port controls |
| rst_n | input | 1 | Asynchronous active-low reset |
| lt_cs_n | input | 1 | Left port select, active low |
| lt_wr_n | input | 1 | Left port write strobe, 0 = write, 1 = read |
| lt_oe_n | input | 1 | Left port output enable, active low |
| lt_addr | input | 10 | Left port address |
| rt_cs_n | input | 1 | Right port select, active low |
| rt_wr_n | input | 1 | Right port write strobe, 0 = write, 1 = read |
| rt_oe_n | input | 1 | Right port output enable, active low |
| rt_addr | input | 10 | Right port address |
| lt_irq_n | output | 1 | Left side interrupt flag, active low |
| rt_irq_n | output | 1 | Right side interrupt flag, active low |

## Verification
The bench drives accesses in several orders:

- The address arrives last. A design that triggers only on the strobe edge would miss this set.
- The output enable arrives last. A design that ignores the output enable would clear too early.
- A read is held while the peer writes. A level-sensitive design would wipe out the fresh message a cycle later.
- A set and a clear land in the same cycle. A design with clear priority would lose the message.

The bench also tries reads of the peer's mailbox, writes to a port's own mailbox and accesses to neighbouring addresses. A design with a wrong or swapped address decode would move a flag on one of these.

// File: rtl/mbox_irq_pkg.sv
`timescale 1ns/1ps
package mbox_irq_pkg;

  // Active-low access qualifiers of one memory port.
  typedef struct packed {
    logic cs_n;
    logic wr_n;
    logic oe_n;
  } port_ctl_t;

  localparam int unsigned NUM_SIDES = 2;

  // Side 0 is the left port, side 1 the right port.
  // The right mailbox is the top address; the left one sits just below it.
  function automatic int unsigned box_offset(int unsigned side);
    return (side == 0) ? 1 : 0;
  endfunction

endpackage

// File: rtl/mbox_port_watch.sv
`timescale 1ns/1ps
module mbox_port_watch #(
  parameter int unsigned         ADDR_W   = 10,
  parameter logic [ADDR_W-1:0]   OWN_BOX  = '1,
  parameter logic [ADDR_W-1:0]   PEER_BOX = '1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  mbox_irq_pkg::port_ctl_t  ctl,
  input  logic [ADDR_W-1:0]        addr,
  output logic                     post_evt,
  output logic                     take_evt
);

  logic post_lvl, take_lvl;
  logic post_lvl_q, take_lvl_q;

  // Complete qualifier sets for posting to the peer and taking from self.
  always_comb begin
    post_lvl = !ctl.cs_n && !ctl.wr_n && (addr == PEER_BOX);
    take_lvl = !ctl.cs_n && ctl.wr_n && !ctl.oe_n && (addr == OWN_BOX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      post_lvl_q <= 1'b0;
      take_lvl_q <= 1'b0;
    end else begin
      post_lvl_q <= post_lvl;
      take_lvl_q <= take_lvl;
    end
  end

  // The event fires only in the cycle the last qualifier arrives.
  always_comb begin
    post_evt = post_lvl && !post_lvl_q;
    take_evt = take_lvl && !take_lvl_q;
  end

endmodule

// File: rtl/mbox_flag.sv
`timescale 1ns/1ps
module mbox_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic irq_n
);

  logic flag_en;
  logic flag_nxt;
  logic flag_q;

  // Set has priority so a message arriving with a clear is kept.
  always_comb begin
    flag_en  = set_evt || clr_evt;
    flag_nxt = set_evt ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b1;
    end else if (flag_en) begin
      flag_q <= flag_nxt;
    end
  end

  assign irq_n = flag_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> !irq_n); // R8

  AST_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !set_evt) |=> irq_n); // R4

  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_evt && !clr_evt) |=> $stable(irq_n)); // R9

endmodule

// File: rtl/mbox_irq_unit.sv
`timescale 1ns/1ps
module mbox_irq_unit #(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lt_cs_n,
  input  logic              lt_wr_n,
  input  logic              lt_oe_n,
  input  logic [ADDR_W-1:0] lt_addr,
  input  logic              rt_cs_n,
  input  logic              rt_wr_n,
  input  logic              rt_oe_n,
  input  logic [ADDR_W-1:0] rt_addr,
  output logic              lt_irq_n,
  output logic              rt_irq_n
);
  import mbox_irq_pkg::*;

  localparam logic [ADDR_W-1:0] TOP_ADDR = '1;
  localparam logic [ADDR_W-1:0] BOX_LT   = TOP_ADDR - ADDR_W'(box_offset(0));
  localparam logic [ADDR_W-1:0] BOX_RT   = TOP_ADDR - ADDR_W'(box_offset(1));

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  port_ctl_t         ctl_v  [NUM_SIDES];
  logic [ADDR_W-1:0] addr_v [NUM_SIDES];
  logic [NUM_SIDES-1:0] post_v, take_v, irq_v;

  always_comb begin
    ctl_v[0]  = '{cs_n: lt_cs_n, wr_n: lt_wr_n, oe_n: lt_oe_n};
    ctl_v[1]  = '{cs_n: rt_cs_n, wr_n: rt_wr_n, oe_n: rt_oe_n};
    addr_v[0] = lt_addr;
    addr_v[1] = rt_addr;
  end

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    localparam logic [ADDR_W-1:0] OWN  = (s == 0) ? BOX_LT : BOX_RT;
    localparam logic [ADDR_W-1:0] PEER = (s == 0) ? BOX_RT : BOX_LT;

    mbox_port_watch #(
      .ADDR_W   (ADDR_W),
      .OWN_BOX  (OWN),
      .PEER_BOX (PEER)
    ) u_watch (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .ctl      (ctl_v[s]),
      .addr     (addr_v[s]),
      .post_evt (post_v[s]),
      .take_evt (take_v[s])
    );

    // A side's flag is set by the peer's post and cleared by its own take.
    mbox_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .set_evt (post_v[NUM_SIDES-1-s]),
      .clr_evt (take_v[s]),
      .irq_n   (irq_v[s])
    );
  end

  assign lt_irq_n = irq_v[0];
  assign rt_irq_n = irq_v[1];

  AST_RT_SET_SOURCE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(rt_irq_n) |-> $past(!lt_cs_n && !lt_wr_n && lt_addr == BOX_RT)); // R2

  AST_LT_SET_SOURCE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(lt_irq_n) |-> $past(!rt_cs_n && !rt_wr_n && rt_addr == BOX_LT)); // R3

  AST_RT_CLR_SOURCE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(rt_irq_n) |-> $past(!rt_cs_n && rt_wr_n && !rt_oe_n && rt_addr == BOX_RT)); // R4

  AST_LT_CLR_SOURCE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(lt_irq_n) |-> $past(!lt_cs_n && lt_wr_n && !lt_oe_n && lt_addr == BOX_LT)); // R5

endmodule

// File: tb/mbox_irq_unit_test.sv
`timescale 1ns/1ps
module mbox_irq_unit_test;

  typedef struct packed {
    logic       cs_n;
    logic       wr_n;
    logic       oe_n;
    logic [9:0] addr;
  } stim_t;

  typedef struct {
    logic  lt;
    logic  rt;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic lt_cs_n, lt_wr_n, lt_oe_n, rt_cs_n, rt_wr_n, rt_oe_n;
  logic [9:0] lt_addr, rt_addr;
  logic lt_irq_n, rt_irq_n;

  exp_t expq[$];
  int   n_checks = 0;
  int   n_fails  = 0;
  bit   done     = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  mbox_irq_unit uut (
    .clk(clk), .rst_n(rst_n),
    .lt_cs_n(lt_cs_n), .lt_wr_n(lt_wr_n), .lt_oe_n(lt_oe_n), .lt_addr(lt_addr),
    .rt_cs_n(rt_cs_n), .rt_wr_n(rt_wr_n), .rt_oe_n(rt_oe_n), .rt_addr(rt_addr),
    .lt_irq_n(lt_irq_n), .rt_irq_n(rt_irq_n)
  );

  localparam stim_t IDLE = '{cs_n: 1'b1, wr_n: 1'b1, oe_n: 1'b1, addr: 10'h000};

  function automatic stim_t wr(logic [9:0] a);
    return '{cs_n: 1'b0, wr_n: 1'b0, oe_n: 1'b1, addr: a};
  endfunction

  function automatic stim_t rd(logic [9:0] a);
    return '{cs_n: 1'b0, wr_n: 1'b1, oe_n: 1'b0, addr: a};
  endfunction

  function automatic stim_t rd_noe(logic [9:0] a);
    return '{cs_n: 1'b0, wr_n: 1'b1, oe_n: 1'b1, addr: a};
  endfunction

  task automatic apply(stim_t l, stim_t r);
    {lt_cs_n, lt_wr_n, lt_oe_n, lt_addr} = l;
    {rt_cs_n, rt_wr_n, rt_oe_n, rt_addr} = r;
  endtask

  // Driver: present one cycle of stimulus and queue the flags expected after the edge.
  task automatic step(stim_t l, stim_t r, logic e_lt, logic e_rt, string req);
    exp_t e;
    @(negedge clk);
    apply(l, r);
    e.lt = e_lt; e.rt = e_rt; e.req = req;
    expq.push_back(e);
    @(posedge clk);
  endtask

  task automatic check_now(logic e_lt, logic e_rt, string req);
    n_checks++;
    if (lt_irq_n !== e_lt || rt_irq_n !== e_rt) begin
      n_fails++;
      $display("FAIL %s: lt_irq_n=%b rt_irq_n=%b expected %b %b", req, lt_irq_n, rt_irq_n, e_lt, e_rt);
    end
  endtask

  // Monitor: compare each queued expectation midway through the high phase.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (expq.size() > 0) begin
        exp_t e;
        e = expq.pop_front();
        check_now(e.lt, e.rt, e.req);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    apply(IDLE, IDLE);
    repeat (3) @(posedge clk);
    #5 check_now(1'b1, 1'b1, "R1 during reset");
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    step(IDLE, IDLE, 1, 1, "R1 after reset");
    step('{cs_n: 1'b1, wr_n: 1'b0, oe_n: 1'b1, addr: 10'h3FF}, IDLE, 1, 1, "R9 deselected write");
    step(wr(10'h3FF), IDLE, 1, 0, "R2 left posts right");
    step(IDLE, IDLE, 1, 0, "R2 hold");
    step(IDLE, rd(10'h3FE), 1, 0, "R9 right reads peer box");
    step(IDLE, wr(10'h3FF), 1, 0, "R9 right writes own box");
    step(IDLE, rd(10'h3FF), 1, 1, "R4 right takes");
    step(IDLE, IDLE, 1, 1, "R4 hold");
    step(IDLE, wr(10'h3FE), 0, 1, "R3 right posts left");
    step(rd(10'h3FF), IDLE, 0, 1, "R9 left reads peer box");
    step(rd(10'h3FD), IDLE, 0, 1, "R9 other address");
    step(rd_noe(10'h3FE), IDLE, 0, 1, "R9 read without output enable");
    step(rd(10'h3FE), IDLE, 1, 1, "R5 R6 output enable last");
    step(IDLE, IDLE, 1, 1, "R5 hold");
    step(wr(10'h100), IDLE, 1, 1, "R9 write elsewhere");
    step(wr(10'h3FF), IDLE, 1, 0, "R6 address last");
    step(IDLE, rd(10'h3FF), 1, 1, "R4 take again");
    step(wr(10'h3FF), rd(10'h3FF), 1, 0, "R7 held read keeps new message");
    step(IDLE, rd(10'h3FF), 1, 0, "R7 held read still no clear");
    step(IDLE, IDLE, 1, 0, "R7 release");
    step(IDLE, rd(10'h3FF), 1, 1, "R4 fresh read clears");
    step(rd_noe(10'h3FF), IDLE, 1, 1, "R9 strobes not yet complete");
    step(wr(10'h3FF), IDLE, 1, 0, "R6 write strobe last");
    step(wr(10'h3FF), rd(10'h3FF), 1, 1, "R7 held write no re-set");
    step(wr(10'h3FF), IDLE, 1, 1, "R7 held write still quiet");
    step(IDLE, IDLE, 1, 1, "R7 release");
    step(wr(10'h3FF), rd(10'h3FF), 1, 0, "R8 right set beats clear");
    step(IDLE, IDLE, 1, 0, "R8 hold");
    step(IDLE, wr(10'h3FE), 0, 0, "R3 left set");
    step(IDLE, IDLE, 0, 0, "R3 hold");
    step(rd(10'h3FE), wr(10'h3FE), 0, 0, "R8 left set beats clear");
    step(IDLE, IDLE, 0, 0, "R8 hold");

    #6 rst_n = 1'b0;
    #2 check_now(1'b1, 1'b1, "R1 reset forces idle");
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    step(IDLE, IDLE, 1, 1, "R1 after second reset");
    repeat (2) @(posedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

endmodule